// File: doc/BRIEF.md
# Burst Parallel ADC Capture Engine

This block runs a pipelined ADC that has two 8-bit parallel outputs. It makes the converter's sample clock from its own fast clock by integer division and samples both byte lanes once per converter clock period. It gathers the bytes of each lane into 32-bit words. Capture happens in bursts. Software, or a sequencer, sets a divide ratio, a sample count and a count of leading samples to discard. It then pulses `start`. The block produces the requested number of samples, delivers the packed words one by one with a valid strobe, stops the converter clock cleanly and pulses an interrupt. The idle gap that follows leaves time to process the captured data.

The converter clock is high for the lower half of each period, rounded down, and low for the rest. The clock starts with a rising edge in the first cycle after a burst is accepted. Each lane is latched at the fast-clock edge that closes the first cycle of a converter-clock high phase. The leading samples are discarded because the converter's pipeline delay makes them invalid. The default count of 7 matches a typical pipeline depth.

Top module: `burst_adc_capture`

## Requirements
- R1: After reset, `adc_clk`, `busy`, `word_valid` and `irq` are all 0.
- R2: A `start` pulse while idle begins a burst only if three conditions hold: `burst_len` is nonzero, `burst_len` is a multiple of 4, and `div_ratio` is at least 2. Any other `start` pulse leaves `busy` and `adc_clk` at 0.
- R3: A `start` pulse during a burst is ignored. Ratio, length and discard count are taken only when a burst is accepted.
- R4: `adc_clk` rises in the first cycle after an accepted start. Its period is `div_ratio` cycles, with `div_ratio/2` (rounded down) cycles high and the remainder low.
- R5: Both lanes are latched at the clock edge that ends the first cycle in which `adc_clk` is high.
- R6: The first `lead_skip` samples of a burst are discarded. A burst produces exactly `lead_skip + burst_len` rising edges of `adc_clk`.
- R7: Each group of 4 kept samples yields one word per lane. Bits [7:0] hold the earliest sample and bits [31:24] the latest. `word_a` carries lane A and `word_b` carries lane B. A burst delivers `burst_len/4` words, each with a one-cycle `word_valid` pulse.
- R8: After the last sample, `adc_clk` finishes its period and stays low. `busy` falls and `irq` pulses for one cycle, `div_ratio` cycles after the last rising edge.
- R9: While idle, `adc_clk` stays low and `word_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock from which the converter clock is divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst request, one cycle |
| burst_len | input | 16 | Kept samples per burst, multiple of 4 |
| div_ratio | input | 8 | Integer divide ratio, at least 2 |
| lead_skip | input | 5 | Leading samples discarded per burst |
| ch_a | input | 8 | Converter lane A data |
| ch_b | input | 8 | Converter lane B data |
| adc_clk | output | 1 | Converter sample clock |
| word_a | output | 32 | Packed lane A word |
| word_b | output | 32 | Packed lane B word |
| word_valid | output | 1 | One-cycle strobe for a new word pair |
| busy | output | 1 | Burst in progress |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `start` is sampled synchronously and that a burst ends only through its own sample count. They do not assume that the control inputs stay stable between bursts, because the block latches them. The stimulus changes the data lanes only just after each observed converter-clock rise, as a real converter would. It also pulses `start` for exactly one cycle, with legal and illegal settings. The mid-burst restart is the one deliberate overlap.

// File: rtl/burst_adc_capture.sv
module burst_adc_capture #(
  parameter int DATA_W = 8,
  parameter int PACK   = 4,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = 16,
  parameter int SKIP_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [LEN_W-1:0]        burst_len,
  input  logic [DIV_W-1:0]        div_ratio,
  input  logic [SKIP_W-1:0]       lead_skip,
  input  logic [DATA_W-1:0]       ch_a,
  input  logic [DATA_W-1:0]       ch_b,
  output logic                    adc_clk,
  output logic [DATA_W*PACK-1:0]  word_a,
  output logic [DATA_W*PACK-1:0]  word_b,
  output logic                    word_valid,
  output logic                    busy,
  output logic                    irq
);
  localparam int WORD_W = DATA_W * PACK;
  localparam int PK_W   = $clog2(PACK);

  logic              run, clk_q;
  logic [DIV_W-1:0]  ph, div_q, hi_q;
  logic [LEN_W-1:0]  rem;
  logic [SKIP_W-1:0] skip_q;
  logic [PK_W-1:0]   bidx;
  logic [WORD_W-1:0] sr_a, sr_b;

  wire len_ok = (burst_len != '0) && (burst_len[PK_W-1:0] == '0);
  wire div_ok = div_ratio > DIV_W'(1);
  wire accept = start && !run && len_ok && div_ok;
  wire strobe = run && (ph == '0);
  wire wrap   = run && (ph == div_q - DIV_W'(1));
  wire done   = (skip_q == '0) && (rem == '0);

  wire [WORD_W-1:0] nxt_a = {ch_a, sr_a[WORD_W-1:DATA_W]};
  wire [WORD_W-1:0] nxt_b = {ch_b, sr_b[WORD_W-1:DATA_W]};

  assign adc_clk = clk_q;
  assign busy    = run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      clk_q      <= 1'b0;
      ph         <= '0;
      div_q      <= '0;
      hi_q       <= '0;
      rem        <= '0;
      skip_q     <= '0;
      bidx       <= '0;
      sr_a       <= '0;
      sr_b       <= '0;
      word_a     <= '0;
      word_b     <= '0;
      word_valid <= 1'b0;
      irq        <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      irq        <= 1'b0;
      if (accept) begin
        run    <= 1'b1;
        clk_q  <= 1'b1;
        ph     <= '0;
        div_q  <= div_ratio;
        hi_q   <= div_ratio >> 1;
        rem    <= burst_len;
        skip_q <= lead_skip;
        bidx   <= '0;
      end else if (run) begin
        if (wrap) begin
          ph <= '0;
          if (done) begin
            run   <= 1'b0;
            clk_q <= 1'b0;
            irq   <= 1'b1;
          end else begin
            clk_q <= 1'b1;
          end
        end else begin
          ph    <= ph + DIV_W'(1);
          clk_q <= (ph + DIV_W'(1)) < hi_q;
        end
        if (strobe) begin
          if (skip_q != '0) begin
            skip_q <= skip_q - SKIP_W'(1);
          end else if (rem != '0) begin
            sr_a <= nxt_a;
            sr_b <= nxt_b;
            rem  <= rem - LEN_W'(1);
            bidx <= bidx + PK_W'(1);
            if (bidx == PK_W'(PACK - 1)) begin
              word_a     <= nxt_a;
              word_b     <= nxt_b;
              word_valid <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

module burst_adc_capture_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic adc_clk,
  input logic busy,
  input logic word_valid,
  input logic irq
);
  a_r9_idle_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !adc_clk);
  a_r9_no_word_idle: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> busy);
  a_r2_begin_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r4_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> adc_clk);
  a_r8_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);
  a_r8_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

bind burst_adc_capture burst_adc_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .adc_clk(adc_clk),
  .busy(busy), .word_valid(word_valid), .irq(irq)
);

// File: tb/tb_burst_adc_capture.sv
module tb_burst_adc_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] burst_len = '0;
  logic [7:0]  div_ratio = '0;
  logic [4:0]  lead_skip = '0;
  logic [7:0]  ch_a = '0, ch_b = '0;
  logic        adc_clk, word_valid, busy, irq;
  logic [31:0] word_a, word_b;

  int total = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  burst_adc_capture dut (
    .clk(clk), .rst_n(rst_n), .start(start), .burst_len(burst_len),
    .div_ratio(div_ratio), .lead_skip(lead_skip), .ch_a(ch_a), .ch_b(ch_b),
    .adc_clk(adc_clk), .word_a(word_a), .word_b(word_b),
    .word_valid(word_valid), .busy(busy), .irq(irq)
  );

  function automatic logic [7:0] fa(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] fb(input int i);
    return 8'((i * 91 + 200) & 255);
  endfunction

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic test_reset();
    @(negedge clk);
    check(adc_clk == 0 && busy == 0, "R1 clk/busy", {adc_clk, busy}, 0);
    check(word_valid == 0 && irq == 0, "R1 valid/irq", {word_valid, irq}, 0);
  endtask

  task automatic run_burst(input int dv, input int ln, input int ld, input bit restart);
    int edges = 0, words = 0, irqs = 0, hi_run = 0, lo_run = 0, since = 0;
    int bad_hi = 0, bad_lo = 0, end_gap = -1, cyc = 0, bad_word = 0;
    bit prev = 0, seen_rise = 0, first_ok = 0;
    logic [31:0] ga [0:63];
    logic [31:0] gb [0:63];
    @(negedge clk);
    div_ratio = 8'(dv); burst_len = 16'(ln); lead_skip = 5'(ld); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    first_ok = adc_clk && busy;
    while (irqs == 0 && cyc < 5000) begin
      if (adc_clk && !prev) begin
        edges++;
        ch_a = fa(edges);
        ch_b = fb(edges);
        if (seen_rise && lo_run != dv - dv / 2) bad_lo++;
        seen_rise = 1; since = 0; hi_run = 1; lo_run = 0;
      end else begin
        since++;
        if (adc_clk) hi_run++;
        else begin
          if (prev && hi_run != dv / 2) bad_hi++;
          lo_run++;
        end
      end
      if (word_valid && words < 64) begin
        ga[words] = word_a; gb[words] = word_b;
      end
      if (word_valid) words++;
      if (irq) begin irqs++; end_gap = since; end
      if (restart && cyc == 5) begin
        start = 1'b1; burst_len = 16'd16; div_ratio = 8'd3; lead_skip = 5'd0;
      end else start = 1'b0;
      prev = adc_clk;
      cyc++;
      if (irqs == 0) @(negedge clk);
    end
    check(first_ok, "R4 first rise after start", first_ok, 1);
    check(bad_hi == 0, "R4 high phase length", bad_hi, 0);
    check(bad_lo == 0, "R4 low phase length", bad_lo, 0);
    check(edges == ld + ln, restart ? "R3 edges unchanged by restart" : "R6 edge count", edges, ld + ln);
    check(words == ln / 4, restart ? "R3 word count unchanged" : "R7 word count", words, ln / 4);
    for (int k = 0; k < ln / 4 && k < 64; k++) begin
      logic [31:0] ea, eb;
      ea = {fa(ld+4*k+4), fa(ld+4*k+3), fa(ld+4*k+2), fa(ld+4*k+1)};
      eb = {fb(ld+4*k+4), fb(ld+4*k+3), fb(ld+4*k+2), fb(ld+4*k+1)};
      if (k < words && (ga[k] != ea || gb[k] != eb)) begin
        bad_word++;
        check(0, "R5 R7 packed word", {ga[k], gb[k]}, {ea, eb});
      end
    end
    check(bad_word == 0, "R5 R6 R7 word contents", bad_word, 0);
    check(irqs == 1, "R8 irq seen", irqs, 1);
    check(end_gap == dv, "R8 stop one period after last rise", end_gap, dv);
    check(!busy && !adc_clk, "R8 idle at irq", {busy, adc_clk}, 0);
    begin
      int act = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (adc_clk || word_valid || busy || irq) act++;
      end
      check(act == 0, "R9 quiet after burst", act, 0);
    end
  endtask

  task automatic bad_start(input int dv, input int ln);
    int act = 0;
    @(negedge clk);
    div_ratio = 8'(dv); burst_len = 16'(ln); lead_skip = 5'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (adc_clk || busy || word_valid) act++;
      @(negedge clk);
    end
    check(act == 0, "R2 start rejected", act, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_burst(6, 8, 7, 1'b0);
    run_burst(5, 12, 7, 1'b0);
    run_burst(2, 4, 0, 1'b0);
    run_burst(4, 8, 2, 1'b1);
    bad_start(4, 6);
    bad_start(4, 0);
    bad_start(1, 8);
    run_burst(3, 16, 1, 1'b0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule